// File: doc/BRIEF.md
# Driver Power-Mode Sequencer

This block is the top-level mode controller of an eight-channel low-side driver. It tracks which global operating mode the device is in: supply lockout, a low-quiescent sleep mode, limp home, global off, global standby and normal per-channel operation. Its inputs are the two supply reset flags (digital and analog), the enable pin, the limp-home pin, and a decoded command event from the serial port. The serial port reports a valid frame and whether that frame was all zeros or all ones.

The block reports the current mode as a 3-bit code. It emits one-cycle pulses that clear the device registers and that ask the serial port to raise its transmission-error flag. It also holds a flag that inhibits open-load diagnostic current after powerup, and a flag that tells the serial port to drop write commands. The enable and limp pins are synchronized and debounced before use. The supply reset flags are only synchronized. Per-channel switching and serial shifting are handled elsewhere.

Top module: `drv_power_sequencer`

## Requirements
- R1: During and right after reset the mode code is lockout. The codes are lockout=0, sleep=1, limp=2, global off=3, global standby=4, normal=5. After reset the inhibit flag is 1, the write-block flag is 1 and both pulses are 0.
- R2: An asserted analog reset flag always forces lockout. An asserted digital reset flag forces lockout only while the filtered limp level is low. Lockout takes precedence over limp home.
- R3: Leaving lockout pulses both the error request and the register reset. The new mode is limp if the limp level is high, otherwise global off if enable is high, otherwise sleep.
- R4: With limp low and enable low, the mode becomes sleep, with a register-reset pulse on entry and no error request. Enable going high in sleep enters global off and pulses both the error request and the register reset.
- R5: A high limp level enters limp whatever the enable level, with no pulses. Leaving limp always pulses the register reset. Leaving into global off (enable high) also pulses the error request. Leaving into sleep (enable low) does not.
- R6: In global off, global standby or normal, a valid all-zeros command enters global standby with a register-reset pulse. An all-ones command enters global off. Any other valid command enters normal.
- R7: The inhibit flag is set on entry to global off from lockout, limp or sleep. It clears on a valid command that is not all ones. An all-ones command leaves it unchanged.
- R8: The write-block flag is high in lockout, sleep and limp. Valid commands have no effect on the mode in those modes.
- R9: The enable and limp pins take effect SYNC_STAGES+HOLD_CYCLES+1 clock edges after a change that stays stable. A pin pulse shorter than HOLD_CYCLES cycles is ignored. The supply reset flags take effect SYNC_STAGES+1 edges after a change. A command takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dig_por_i | input | 1 | Digital supply below reset threshold |
| ana_por_i | input | 1 | Analog supply below reset threshold |
| en_i | input | 1 | Enable pin level (asynchronous) |
| limp_i | input | 1 | Limp-home pin level (asynchronous) |
| cmd_valid_i | input | 1 | One-cycle strobe: a correctly framed command arrived |
| cmd_all_zero_i | input | 1 | With strobe: command word was all zeros |
| cmd_all_one_i | input | 1 | With strobe: command word was all ones |
| mode_o | output | 3 | Current mode code |
| reg_reset_o | output | 1 | One-cycle register clear request |
| err_set_o | output | 1 | One-cycle transmission-error set request |
| diag_inhibit_o | output | 1 | Open-load diagnostic current inhibited |
| wr_block_o | output | 1 | Serial writes must be ignored |

## Verification
Each result has a fixed delay from its stimulus. A pin change shows up SYNC_STAGES+HOLD_CYCLES+1 edges later, a supply flag change SYNC_STAGES+1 edges later, and a command strobe one edge later. The pulses are visible for exactly the cycle after the mode-changing edge. For every stimulus, the driver queues the expected mode, the flags and both pulses, together with the matching delay. The monitor counts that many rising edges and samples one nanosecond after the last one, so the pulses are caught in their single valid cycle. For ignored events (a short enable glitch, commands while writes are blocked, the digital flag during limp), the bench waits beyond the normal delay and then checks that the mode is unchanged.

// File: rtl/drv_pwr_pkg.sv
package drv_pwr_pkg;

    typedef enum logic [2:0] {
        MD_LOCKOUT = 3'd0,
        MD_SLEEP   = 3'd1,
        MD_LIMP    = 3'd2,
        MD_GOFF    = 3'd3,
        MD_GSTBY   = 3'd4,
        MD_NORMAL  = 3'd5
    } pwr_mode_e;

    typedef struct packed {
        logic dig_por;
        logic ana_por;
        logic en;
        logic limp;
    } pwr_levels_t;

    typedef struct packed {
        logic valid;
        logic all_zero;
        logic all_one;
    } pwr_cmd_t;

    typedef struct packed {
        pwr_mode_e mode;
        logic      diag_inhibit;
        logic      reg_reset;
        logic      err_set;
    } pwr_ctrl_t;

    localparam pwr_ctrl_t CTRL_RESET = '{mode: MD_LOCKOUT, diag_inhibit: 1'b1,
                                         reg_reset: 1'b0, err_set: 1'b0};

    function automatic logic writes_blocked(pwr_mode_e m);
        return (m == MD_LOCKOUT) || (m == MD_SLEEP) || (m == MD_LIMP);
    endfunction

    function automatic logic in_lockout(pwr_levels_t l);
        return l.ana_por | (l.dig_por & ~l.limp);
    endfunction

    function automatic pwr_mode_e wake_target(pwr_levels_t l);
        if (l.limp)    return MD_LIMP;
        else if (l.en) return MD_GOFF;
        else           return MD_SLEEP;
    endfunction

endpackage

// File: rtl/drv_pwr_level_filter.sv
module drv_pwr_level_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   HOLD_CYCLES = 4,
    parameter logic RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   stable_w;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= {SYNC_STAGES{RST_VAL}};
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    assign stable_w = sync_q[SYNC_STAGES-1];

    generate
        if (HOLD_CYCLES == 0) begin : g_direct
            assign level_o = stable_w;
        end else begin : g_hold
            localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
            localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
            logic [CW-1:0] cnt_q;
            logic          lvl_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                    lvl_q <= RST_VAL;
                end else if (stable_w == lvl_q) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    lvl_q <= stable_w;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign level_o = lvl_q;
        end
    endgenerate
endmodule

// File: rtl/drv_pwr_next_mode.sv
module drv_pwr_next_mode
    import drv_pwr_pkg::*;
(
    input  pwr_ctrl_t   cur_i,
    input  pwr_levels_t lvl_i,
    input  pwr_cmd_t    cmd_i,
    output pwr_ctrl_t   nxt_o
);
    always_comb begin
        nxt_o           = cur_i;
        nxt_o.reg_reset = 1'b0;
        nxt_o.err_set   = 1'b0;
        if (in_lockout(lvl_i)) begin
            nxt_o.mode = MD_LOCKOUT;
        end else if (cur_i.mode == MD_LOCKOUT) begin
            nxt_o.mode      = wake_target(lvl_i);
            nxt_o.err_set   = 1'b1;
            nxt_o.reg_reset = 1'b1;
            if (wake_target(lvl_i) == MD_GOFF) nxt_o.diag_inhibit = 1'b1;
        end else if (lvl_i.limp) begin
            nxt_o.mode = MD_LIMP;
        end else if (cur_i.mode == MD_LIMP) begin
            nxt_o.mode      = wake_target(lvl_i);
            nxt_o.reg_reset = 1'b1;
            if (lvl_i.en) begin
                nxt_o.err_set      = 1'b1;
                nxt_o.diag_inhibit = 1'b1;
            end
        end else if (!lvl_i.en) begin
            nxt_o.mode      = MD_SLEEP;
            nxt_o.reg_reset = (cur_i.mode != MD_SLEEP);
        end else if (cur_i.mode == MD_SLEEP) begin
            nxt_o.mode         = MD_GOFF;
            nxt_o.err_set      = 1'b1;
            nxt_o.reg_reset    = 1'b1;
            nxt_o.diag_inhibit = 1'b1;
        end else if (cmd_i.valid) begin
            if (cmd_i.all_one) begin
                nxt_o.mode = MD_GOFF;
            end else begin
                nxt_o.diag_inhibit = 1'b0;
                nxt_o.reg_reset    = cmd_i.all_zero;
                nxt_o.mode         = cmd_i.all_zero ? MD_GSTBY : MD_NORMAL;
            end
        end
    end
endmodule

// File: rtl/drv_pwr_mode_reg.sv
module drv_pwr_mode_reg
    import drv_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pwr_ctrl_t nxt_i,
    output pwr_ctrl_t cur_o
);
    always_ff @(posedge clk) begin
        if (rst) cur_o <= CTRL_RESET;
        else     cur_o <= nxt_i;
    end
endmodule

// File: rtl/drv_power_sequencer.sv
module drv_power_sequencer
    import drv_pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dig_por_i,
    input  logic       ana_por_i,
    input  logic       en_i,
    input  logic       limp_i,
    input  logic       cmd_valid_i,
    input  logic       cmd_all_zero_i,
    input  logic       cmd_all_one_i,
    output logic [2:0] mode_o,
    output logic       reg_reset_o,
    output logic       err_set_o,
    output logic       diag_inhibit_o,
    output logic       wr_block_o
);
    localparam int NUM_IN = 4;

    logic [NUM_IN-1:0] raw_w;
    logic [NUM_IN-1:0] lvl_w;
    pwr_levels_t       levels;
    pwr_cmd_t          cmd;
    pwr_ctrl_t         cur;
    pwr_ctrl_t         nxt;

    // index 0/1: supply flags (sync only, reset asserted); 2/3: pins (debounced)
    assign raw_w = {limp_i, en_i, ana_por_i, dig_por_i};

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        localparam bit IS_SUPPLY = (gi < 2);
        drv_pwr_level_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_CYCLES (IS_SUPPLY ? 0 : HOLD_CYCLES),
            .RST_VAL     (IS_SUPPLY ? 1'b1 : 1'b0)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_w[gi]),
            .level_o (lvl_w[gi])
        );
    end

    assign levels = '{dig_por: lvl_w[0], ana_por: lvl_w[1], en: lvl_w[2], limp: lvl_w[3]};
    assign cmd    = '{valid: cmd_valid_i, all_zero: cmd_all_zero_i, all_one: cmd_all_one_i};

    drv_pwr_next_mode u_next (
        .cur_i (cur),
        .lvl_i (levels),
        .cmd_i (cmd),
        .nxt_o (nxt)
    );

    drv_pwr_mode_reg u_state (
        .clk   (clk),
        .rst   (rst),
        .nxt_i (nxt),
        .cur_o (cur)
    );

    assign mode_o         = cur.mode;
    assign reg_reset_o    = cur.reg_reset;
    assign err_set_o      = cur.err_set;
    assign diag_inhibit_o = cur.diag_inhibit;
    assign wr_block_o     = writes_blocked(cur.mode);
endmodule

// File: rtl/drv_power_sequencer_chk.sv
module drv_power_sequencer_chk
    import drv_pwr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid_i,
    input logic [2:0] mode_o,
    input logic       reg_reset_o,
    input logic       err_set_o,
    input logic       diag_inhibit_o,
    input logic       wr_block_o
);
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode_o <= 3'd5);

    a_r3_err_needs_mode_change: assert property (@(posedge clk) disable iff (rst)
        err_set_o |-> (mode_o != $past(mode_o)));

    a_r5_limp_exit_pulses: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == MD_LIMP && mode_o == MD_GOFF)
            |-> (err_set_o && reg_reset_o && diag_inhibit_o));

    a_r7_inhibit_rise_in_goff: assert property (@(posedge clk) disable iff (rst)
        $rose(diag_inhibit_o) |-> (mode_o == MD_GOFF));

    a_r7_inhibit_fall_by_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(diag_inhibit_o) |-> $past(cmd_valid_i));

    a_r8_blocked_cmd_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_block_o && cmd_valid_i) |=> (mode_o != MD_NORMAL && mode_o != MD_GSTBY));
endmodule

bind drv_power_sequencer drv_power_sequencer_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid_i    (cmd_valid_i),
    .mode_o         (mode_o),
    .reg_reset_o    (reg_reset_o),
    .err_set_o      (err_set_o),
    .diag_inhibit_o (diag_inhibit_o),
    .wr_block_o     (wr_block_o)
);

// File: tb/drv_power_sequencer_bench.sv
module drv_power_sequencer_bench;
    localparam int SYNC  = 2;
    localparam int HOLD  = 4;
    localparam int L_PIN = SYNC + HOLD + 1;
    localparam int L_POR = SYNC + 1;

    localparam logic [2:0] M_LOCK = 3'd0, M_SLEEP = 3'd1, M_LIMP = 3'd2,
                           M_GOFF = 3'd3, M_GSTBY = 3'd4, M_NORM = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dig_por = 1'b1, ana_por = 1'b1, en = 1'b0, limp = 1'b0;
    logic cmd_valid = 1'b0, cmd_zero = 1'b0, cmd_one = 1'b0;
    logic [2:0] mode;
    logic reg_reset, err_set, inhibit, wr_block;

    always #2 clk = ~clk;

    drv_power_sequencer #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u_drv_power_sequencer (
        .clk (clk), .rst (rst),
        .dig_por_i (dig_por), .ana_por_i (ana_por), .en_i (en), .limp_i (limp),
        .cmd_valid_i (cmd_valid), .cmd_all_zero_i (cmd_zero), .cmd_all_one_i (cmd_one),
        .mode_o (mode), .reg_reset_o (reg_reset), .err_set_o (err_set),
        .diag_inhibit_o (inhibit), .wr_block_o (wr_block)
    );

    typedef struct packed {
        logic [15:0] lat;
        logic [2:0]  mode;
        logic        inh, wb, err, rr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    pending = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    task automatic push(int lat, logic [2:0] m, logic inh, logic wb, logic err, logic rr, string tag);
        exp_t e;
        e.lat = 16'(lat); e.mode = m; e.inh = inh; e.wb = wb; e.err = err; e.rr = rr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        pending++;
    endtask

    task automatic settle();
        wait (pending == 0);
        @(negedge clk);
    endtask

    task automatic send_cmd(logic z, logic o, logic [2:0] m, logic inh, logic wb, logic rr, string tag);
        cmd_valid = 1'b1; cmd_zero = z; cmd_one = o;
        push(1, m, inh, wb, 1'b0, rr, tag);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_zero = 1'b0; cmd_one = 1'b0;
        settle();
    endtask

    // monitor: pops expectations and samples after the due edge
    initial begin
        forever begin
            exp_t  e;
            string t;
            wait (pending > 0);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int k = 0; k < int'(e.lat); k++) @(posedge clk);
            #1;
            checks++;
            if ({mode, inhibit, wr_block, err_set, reg_reset} !== {e.mode, e.inh, e.wb, e.err, e.rr}) begin
                errors++;
                $display("FAIL %s: got mode=%0d inh=%b wb=%b err=%b rr=%b, expected mode=%0d inh=%b wb=%b err=%b rr=%b",
                         t, mode, inhibit, wr_block, err_set, reg_reset,
                         e.mode, e.inh, e.wb, e.err, e.rr);
            end
            pending--;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        push(0, M_LOCK, 1, 1, 0, 0, "R1 reset state");
        settle();

        dig_por = 0; ana_por = 0;
        push(L_POR, M_SLEEP, 1, 1, 1, 1, "R3 leave lockout to sleep (R9 supply latency)");
        settle();

        en = 1;
        push(L_PIN, M_GOFF, 1, 0, 1, 1, "R4 enable high from sleep (R9 pin latency)");
        settle();

        send_cmd(0, 1, M_GOFF, 1, 0, 0, "R7 all-ones keeps inhibit");
        send_cmd(0, 0, M_NORM, 0, 0, 0, "R7 mixed command clears inhibit, R6 normal");
        send_cmd(1, 0, M_GSTBY, 0, 0, 1, "R6 all-zeros gives standby");
        send_cmd(0, 1, M_GOFF, 0, 0, 0, "R6 all-ones gives global off");
        send_cmd(0, 0, M_NORM, 0, 0, 0, "R6 mixed command gives normal");

        en = 0;
        repeat (HOLD - 2) @(negedge clk);
        en = 1;
        push(L_PIN + 2, M_NORM, 0, 0, 0, 0, "R9 short enable glitch ignored");
        settle();

        limp = 1;
        push(L_PIN, M_LIMP, 0, 1, 0, 0, "R5 enter limp with enable high");
        settle();
        send_cmd(0, 0, M_LIMP, 0, 1, 0, "R8 command ignored in limp");

        dig_por = 1;
        push(L_POR + 2, M_LIMP, 0, 1, 0, 0, "R2 digital reset ignored in limp");
        settle();
        dig_por = 0;
        push(L_POR, M_LIMP, 0, 1, 0, 0, "R2 limp held after digital reset clears");
        settle();

        limp = 0;
        push(L_PIN, M_GOFF, 1, 0, 1, 1, "R5 leave limp into global off");
        settle();
        send_cmd(0, 0, M_NORM, 0, 0, 0, "R6 normal after limp exit");

        en = 0;
        push(L_PIN, M_SLEEP, 0, 1, 0, 1, "R4 enable low gives sleep with reset");
        settle();
        send_cmd(1, 0, M_SLEEP, 0, 1, 0, "R8 command ignored in sleep");

        limp = 1;
        push(L_PIN, M_LIMP, 0, 1, 0, 0, "R5 enter limp with enable low");
        settle();
        limp = 0;
        push(L_PIN, M_SLEEP, 0, 1, 0, 1, "R5 leave limp into sleep, no error");
        settle();

        ana_por = 1;
        push(L_POR, M_LOCK, 0, 1, 0, 0, "R2 analog reset gives lockout");
        settle();
        limp = 1;
        push(L_PIN + 1, M_LOCK, 0, 1, 0, 0, "R2 lockout wins over limp");
        settle();
        ana_por = 0;
        push(L_POR, M_LIMP, 0, 1, 1, 1, "R3 leave lockout into limp");
        settle();

        dig_por = 1;
        push(L_POR, M_LIMP, 0, 1, 0, 0, "R2 digital reset during limp");
        settle();
        limp = 0;
        push(L_PIN, M_LOCK, 0, 1, 0, 0, "R2 digital reset counts once limp drops");
        settle();
        dig_por = 0;
        push(L_POR, M_SLEEP, 0, 1, 1, 1, "R3 leave lockout with enable low");
        settle();
        en = 1;
        push(L_PIN, M_GOFF, 1, 0, 1, 1, "R7 inhibit set entering global off from sleep");
        settle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule